// File: doc/BRIEF.md
# MDIO management master controller

This block is a memory-mapped master for the two-wire PHY management bus. Software sees two registers: a control register and a 16-bit data register. The control register holds the PHY address, the PHY register index, a clock-range code, a write flag and a busy flag. Software starts a transfer by writing the control register with the busy flag set. The controller then divides the system clock to produce MDC and shifts out a complete management frame on MDIO. On a read it releases the line and samples the PHY's answer. When the last bit has gone by, it clears busy.

No acknowledgment ever comes back from the PHY. Every frame therefore takes a fixed number of MDC periods, whether or not a device answers. While a frame is running, register writes are refused, so the transfer in progress cannot be disturbed. The clock-range code selects either a standard divisor, which keeps MDC inside the usual 1.0 to 2.5 MHz band, or one of eight small even divisors for PHYs that accept a faster clock.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: Control register (reg_addr = 0) layout: PHY address in bits 15:11, PHY register index in bits 10:6, clock-range code in bits 5:2, write flag in bit 1, busy in bit 0, with bits 31:16 reading zero. The data register (reg_addr = 1) reads its 16 bits in 15:0 with 31:16 zero. Both registers reset to all zeros.
- R2: Writing the control register with bit 0 = 1 while idle starts a frame. Busy then reads 1 until the controller clears it at the end of the frame. A control write with bit 0 = 0 starts nothing and leaves MDC low.
- R3: While busy is 1, writes to either register are ignored. The latched fields and the data register keep their values, the frame on the wire is unaffected, and no second frame starts.
- R4: A write frame (write flag = 1) is sent MSB first as 32 ones, 01, opcode 01, the 5-bit PHY address, the 5-bit register index, turnaround 10, then the 16 data-register bits. MDIO is driven for all 64 bits.
- R5: A read frame uses opcode 10. MDIO output enable is low from the first turnaround bit (bit index 46) through the last data bit. The 16 bits sampled on the MDC rising edges of bits 48 to 63 are placed in the data register when busy clears.
- R6: A frame lasts exactly 64 MDC periods, that is 64 × divisor system-clock cycles of busy, with or without a PHY. A read with no PHY on a pulled-up line returns 0xFFFF.
- R7: The MDC period in system clocks is set by the clock-range code. Codes 0, 1, 2, 3, 4 and 5 give 42, 62, 16, 26, 102 and 124. Codes 6 and 7 give 42. Codes 8 to 15 give 4 + 2 × (code − 8), so code 10 gives 8.
- R8: MDC is low whenever the controller is idle. While driving during a frame, MDIO changes only on a falling edge of MDC, and read data is sampled on the rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 control, 1 data |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO value driven when enabled |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO line as seen at the pad |

## Verification
The hardest situation to reach from the ports is a register write that lands in the middle of a running frame. That write would start a new frame if it were accepted while idle. To get there, the bench starts a fast write frame and then, while busy still reads 1, issues a control write with a new PHY address and the busy bit set, followed by a data write. It then checks the captured bit stream, the register read-back and the idle state afterwards. A behavioural PHY in the bench answers reads with a known word through the released line. The no-PHY case relies on the pull-up alone.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int PHY_AW  = 5;
    localparam int REG_AW  = 5;
    localparam int RANGE_W = 4;
    localparam int DATA_W  = 16;
    localparam int DIV_W   = 7;
    localparam int FAST_BASE = 4;

    localparam logic [1:0] SOF_BITS = 2'b01;
    localparam logic [1:0] OP_WR    = 2'b01;
    localparam logic [1:0] OP_RD    = 2'b10;
    localparam logic [1:0] TA_WR    = 2'b10;

    typedef enum logic {
        SEL_CTRL = 1'b0,
        SEL_DATA = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic [PHY_AW-1:0]  phy;
        logic [REG_AW-1:0]  reg_idx;
        logic [RANGE_W-1:0] range;
        logic               wr;
    } mdio_ctrl_t;

    localparam int CTRL_W = $bits(mdio_ctrl_t);

    function automatic logic [DIV_W-1:0] range_divisor(input logic [RANGE_W-1:0] code);
        logic [DIV_W-1:0] d;
        if (code[RANGE_W-1]) begin
            d = DIV_W'(FAST_BASE) + DIV_W'({code[RANGE_W-2:0], 1'b0});
        end else begin
            case (code[RANGE_W-2:0])
                3'd1:    d = DIV_W'(62);
                3'd2:    d = DIV_W'(16);
                3'd3:    d = DIV_W'(26);
                3'd4:    d = DIV_W'(102);
                3'd5:    d = DIV_W'(124);
                default: d = DIV_W'(42);
            endcase
        end
        return d;
    endfunction

endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv
    import mdio_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] divisor,
    output logic             mdc,
    output logic             rise,
    output logic             fall
);

    localparam int HW = DIV_W - 1;

    logic [HW-1:0] cnt;
    logic [HW-1:0] half_m1;
    logic          wrap;
    logic          unused_lsb;

    // Even divisors only: half period is divisor/2 system clocks.
    assign half_m1    = divisor[DIV_W-1:1] - HW'(1);
    assign unused_lsb = divisor[0];
    assign wrap       = run && (cnt == half_m1);
    assign rise       = wrap && !mdc;
    assign fall       = wrap && mdc;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (wrap) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + HW'(1);
        end
    end

endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
    import mdio_pkg::*;
#(
    parameter int PRE_LEN = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [PHY_AW-1:0] phy,
    input  logic [REG_AW-1:0] reg_idx,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rise,
    input  logic              fall,
    input  logic              mdio_i,
    output logic              busy,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              rd_done,
    output logic [DATA_W-1:0] rd_data
);

    localparam int FRAME_LEN = PRE_LEN + 4 + PHY_AW + REG_AW + 2 + DATA_W;
    localparam int CNT_W     = $clog2(FRAME_LEN);
    localparam int TA_POS    = FRAME_LEN - DATA_W - 2;
    localparam int DATA_POS  = FRAME_LEN - DATA_W;

    logic [FRAME_LEN-1:0] shreg;
    logic [CNT_W-1:0]     idx;
    logic                 wr_q;
    logic [DATA_W-1:0]    cap;
    logic                 last;

    assign last    = (idx == CNT_W'(FRAME_LEN - 1));
    assign mdio_o  = busy && shreg[FRAME_LEN-1];
    assign mdio_oe = busy && (wr_q || (idx < CNT_W'(TA_POS)));
    assign rd_done = busy && fall && last && !wr_q;
    assign rd_data = cap;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            idx   <= '0;
            shreg <= '0;
            wr_q  <= 1'b0;
            cap   <= '0;
        end else begin
            if (start && !busy) begin
                busy  <= 1'b1;
                idx   <= '0;
                wr_q  <= wr;
                shreg <= {{PRE_LEN{1'b1}}, SOF_BITS, (wr ? OP_WR : OP_RD),
                          phy, reg_idx, (wr ? TA_WR : 2'b11),
                          (wr ? wdata : {DATA_W{1'b1}})};
            end else if (busy && fall) begin
                if (last) begin
                    busy <= 1'b0;
                end else begin
                    idx   <= idx + CNT_W'(1);
                    shreg <= {shreg[FRAME_LEN-2:0], 1'b1};
                end
            end
            if (busy && rise && !wr_q && (idx >= CNT_W'(DATA_POS))) begin
                cap <= {cap[DATA_W-2:0], mdio_i};
            end
        end
    end

endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
    import mdio_pkg::*;
#(
    parameter int BUS_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic              addr,
    input  logic [BUS_W-1:0]  wdata,
    input  logic              busy,
    input  logic              rd_done,
    input  logic [DATA_W-1:0] rd_data,
    output mdio_ctrl_t        ctrl_q,
    output logic [DATA_W-1:0] data_q,
    output logic              start,
    output logic [PHY_AW-1:0] new_phy,
    output logic [REG_AW-1:0] new_reg,
    output logic              new_wr,
    output logic [BUS_W-1:0]  rdata
);

    reg_sel_e   sel;
    logic       accept;
    mdio_ctrl_t cmd;
    logic       unused_hi;

    assign sel       = reg_sel_e'(addr);
    assign accept    = we && !busy;
    assign cmd       = mdio_ctrl_t'(wdata[CTRL_W:1]);
    assign start     = accept && (sel == SEL_CTRL) && wdata[0];
    assign new_phy   = cmd.phy;
    assign new_reg   = cmd.reg_idx;
    assign new_wr    = cmd.wr;
    assign unused_hi = ^wdata[BUS_W-1:CTRL_W+1];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            data_q <= '0;
        end else begin
            if (accept && (sel == SEL_CTRL)) begin
                ctrl_q <= cmd;
            end
            if (accept && (sel == SEL_DATA)) begin
                data_q <= wdata[DATA_W-1:0];
            end else if (rd_done) begin
                data_q <= rd_data;
            end
        end
    end

    always_comb begin
        if (sel == SEL_CTRL) begin
            rdata = BUS_W'({ctrl_q, busy});
        end else begin
            rdata = BUS_W'(data_q);
        end
    end

endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
    import mdio_pkg::*;
#(
    parameter int BUS_W   = 32,
    parameter int PRE_LEN = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_we,
    input  logic             reg_addr,
    input  logic [BUS_W-1:0] reg_wdata,
    output logic [BUS_W-1:0] reg_rdata,
    output logic             mdc,
    output logic             mdio_o,
    output logic             mdio_oe,
    input  logic             mdio_i
);

    mdio_ctrl_t        ctrl_q;
    logic [DATA_W-1:0] data_q;
    logic              start;
    logic [PHY_AW-1:0] new_phy;
    logic [REG_AW-1:0] new_reg;
    logic              new_wr;
    logic              busy;
    logic              rd_done;
    logic [DATA_W-1:0] rd_data;
    logic              rise;
    logic              fall;
    logic [DIV_W-1:0]  divisor;

    assign divisor = range_divisor(ctrl_q.range);

    mdio_regs #(.BUS_W(BUS_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .we      (reg_we),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .busy    (busy),
        .rd_done (rd_done),
        .rd_data (rd_data),
        .ctrl_q  (ctrl_q),
        .data_q  (data_q),
        .start   (start),
        .new_phy (new_phy),
        .new_reg (new_reg),
        .new_wr  (new_wr),
        .rdata   (reg_rdata)
    );

    mdio_clkdiv u_div (
        .clk     (clk),
        .rst     (rst),
        .run     (busy),
        .divisor (divisor),
        .mdc     (mdc),
        .rise    (rise),
        .fall    (fall)
    );

    mdio_frame #(.PRE_LEN(PRE_LEN)) u_frame (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .phy     (new_phy),
        .reg_idx (new_reg),
        .wr      (new_wr),
        .wdata   (data_q),
        .rise    (rise),
        .fall    (fall),
        .mdio_i  (mdio_i),
        .busy    (busy),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe),
        .rd_done (rd_done),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/mdio_mgmt_ctrl_chk.sv
module mdio_mgmt_ctrl_chk
    import mdio_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              reg_we,
    input logic              reg_addr,
    input logic              start_bit,
    input logic              mdc,
    input logic              mdio_o,
    input logic              mdio_oe,
    input logic              busy,
    input logic [CTRL_W-1:0] ctrl_q
);

    AST_BUSY_SW_SET: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> ($past(reg_we) && !$past(reg_addr) && $past(start_bit))); // R2

    AST_BUSY_CLR_AT_FALL: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> ($past(mdc) && !mdc)); // R2

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(ctrl_q)); // R3

    AST_IDLE_MDC_LOW: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mdc); // R8

    AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mdio_oe); // R8

    AST_OUT_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && mdio_oe && $past(mdio_oe) && !$stable(mdio_o))
            |-> ($past(mdc) && !mdc)); // R8

endmodule

bind mdio_mgmt_ctrl mdio_mgmt_ctrl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .start_bit (reg_wdata[0]),
    .mdc       (mdc),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .busy      (busy),
    .ctrl_q    (ctrl_q)
);

// File: tb/tb_mdio_mgmt_ctrl.sv
`timescale 1ns/1ps
module tb_mdio_mgmt_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic        reg_addr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc;
    logic        mdio_o;
    logic        mdio_oe;
    logic        mdio_i;

    always #5 clk = ~clk;

    mdio_mgmt_ctrl dut (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .mdc       (mdc),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .mdio_i    (mdio_i)
    );

    int  n_checks = 0;
    int  n_fail = 0;
    bit  done = 0;

    // Behavioural PHY and line model (pull-up when nobody drives)
    logic        phy_en = 1'b0;
    logic [15:0] phy_val = '0;
    logic        phy_drv = 1'b0;
    logic        phy_bit = 1'b0;
    int          rise_cnt = 0;
    logic [63:0] cap_bits = '0;
    int          oe_late = 0;
    time         last_rise = 0;
    time         mdc_per = 0;
    int          edge_viol = 0;
    logic        prev_o = 1'b0;
    logic        prev_mdc = 1'b0;
    logic        prev_oe = 1'b0;

    assign mdio_i = mdio_oe ? mdio_o : (phy_drv ? phy_bit : 1'b1);

    always @(posedge mdc) begin
        cap_bits = {cap_bits[62:0], mdio_i};
        if (rise_cnt >= 46 && mdio_oe) oe_late++;
        mdc_per   = $time - last_rise;
        last_rise = $time;
        rise_cnt++;
    end

    always @(negedge mdc) begin
        if (phy_en && rise_cnt == 47) begin
            phy_drv = 1'b1;
            phy_bit = 1'b0;
        end else if (phy_en && rise_cnt >= 48 && rise_cnt < 64) begin
            phy_drv = 1'b1;
            phy_bit = phy_val[63 - rise_cnt];
        end else begin
            phy_drv = 1'b0;
        end
    end

    always @(negedge clk) begin
        if (prev_oe && mdio_oe && (mdio_o !== prev_o) && !(prev_mdc && !mdc)) edge_viol++;
        prev_o   = mdio_o;
        prev_mdc = mdc;
        prev_oe  = mdio_oe;
    end

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic reg_write(input logic a, input logic [31:0] d);
        @(negedge clk);
        reg_we    = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic reg_read(input logic a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle(output int cyc);
        reg_addr = 1'b0;
        cyc = 0;
        #1;
        while (reg_rdata[0] && cyc < 20000) begin
            cyc++;
            @(negedge clk);
            #1;
        end
    endtask

    function automatic logic [31:0] ctrl_word(input logic [4:0] pa, input logic [4:0] ra,
                                              input logic [3:0] code, input logic wr,
                                              input logic go);
        return {16'h0, pa, ra, code, wr, go};
    endfunction

    task automatic start_xfer(input logic [4:0] pa, input logic [4:0] ra,
                              input logic [3:0] code, input logic wr);
        rise_cnt = 0;
        oe_late  = 0;
        reg_write(1'b0, ctrl_word(pa, ra, code, wr, 1'b1));
    endtask

    task automatic t_reset();
        logic [31:0] v;
        reg_read(1'b0, v);
        chk("R1", "control after reset", 64'(v), 64'h0);
        reg_read(1'b1, v);
        chk("R1", "data after reset", 64'(v), 64'h0);
        chk("R8", "mdc after reset", 64'(mdc), 64'h0);
        chk("R8", "oe after reset", 64'(mdio_oe), 64'h0);
    endtask

    task automatic t_fields();
        logic [31:0] v;
        reg_write(1'b0, {16'hFFFF, 5'h15, 5'h0B, 4'hA, 1'b1, 1'b0});
        reg_read(1'b0, v);
        chk("R1", "control field layout", 64'(v), 64'(ctrl_word(5'h15, 5'h0B, 4'hA, 1'b1, 1'b0)));
        reg_write(1'b1, 32'hFFFF_BEEF);
        reg_read(1'b1, v);
        chk("R1", "data register readback", 64'(v), 64'h0000_BEEF);
        repeat (20) @(negedge clk);
        chk("R2", "no start without busy bit: mdc", 64'(mdc), 64'h0);
        reg_read(1'b0, v);
        chk("R2", "no start without busy bit: busy", 64'(v[0]), 64'h0);
    endtask

    task automatic t_write();
        logic [31:0] v;
        int          cyc;
        logic [63:0] exp;
        phy_en = 1'b0;
        reg_write(1'b1, 32'h0000_A5C3);
        start_xfer(5'h13, 5'h0A, 4'd8, 1'b1);
        repeat (10) @(negedge clk);
        reg_write(1'b0, ctrl_word(5'h1F, 5'h01, 4'd0, 1'b0, 1'b1));
        reg_write(1'b1, 32'h0000_1234);
        wait_idle(cyc);
        exp = {32'hFFFF_FFFF, 2'b01, 2'b01, 5'h13, 5'h0A, 2'b10, 16'hA5C3};
        chk("R4", "write frame bit stream", cap_bits, exp);
        chk("R4", "write frame MDC rising edges", 64'(rise_cnt), 64'd64);
        reg_read(1'b0, v);
        chk("R3", "control unchanged by write during busy", 64'(v),
            64'(ctrl_word(5'h13, 5'h0A, 4'd8, 1'b1, 1'b0)));
        reg_read(1'b1, v);
        chk("R3", "data unchanged by write during busy", 64'(v), 64'h0000_A5C3);
        repeat (40) @(negedge clk);
        chk("R3", "no second frame started: mdc idle", 64'(mdc), 64'h0);
        chk("R8", "output changed only on MDC fall", 64'(edge_viol), 64'h0);
    endtask

    task automatic t_read_phy();
        logic [31:0] v;
        int          cyc;
        logic [63:0] exp;
        phy_en  = 1'b1;
        phy_val = 16'h3C96;
        start_xfer(5'h05, 5'h1E, 4'd10, 1'b0);
        wait_idle(cyc);
        reg_read(1'b1, v);
        chk("R5", "read data from PHY", 64'(v), 64'h0000_3C96);
        exp = {32'hFFFF_FFFF, 2'b01, 2'b10, 5'h05, 5'h1E, 2'b10, 16'h3C96};
        chk("R5", "read frame bit stream", cap_bits, exp);
        chk("R5", "oe low from turnaround on", 64'(oe_late), 64'h0);
        chk("R7", "code 10 MDC period ns", 64'(mdc_per), 64'd80);
        chk("R8", "mdc low after read", 64'(mdc), 64'h0);
        phy_en = 1'b0;
    endtask

    task automatic t_read_nophy();
        logic [31:0] v;
        int          cyc;
        phy_en = 1'b0;
        start_xfer(5'h00, 5'h02, 4'd9, 1'b0);
        wait_idle(cyc);
        chk("R6", "busy cycles without PHY (64 x 6)", 64'(cyc), 64'd384);
        reg_read(1'b1, v);
        chk("R6", "read without PHY", 64'(v), 64'h0000_FFFF);
    endtask

    task automatic t_period(input logic [3:0] code, input int div);
        int cyc;
        start_xfer(5'h01, 5'h01, code, 1'b0);
        wait_idle(cyc);
        chk("R7", $sformatf("MDC period ns for code %0d", code), 64'(mdc_per), 64'(div * 10));
        chk("R6", $sformatf("busy cycles for code %0d", code), 64'(cyc), 64'(div * 64));
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        t_reset();
        t_fields();
        t_write();
        t_read_phy();
        t_read_nophy();
        t_period(4'd0, 42);
        t_period(4'd1, 62);
        t_period(4'd2, 16);
        t_period(4'd3, 26);
        t_period(4'd4, 102);
        t_period(4'd5, 124);
        t_period(4'd7, 42);
        t_period(4'd8, 4);
        t_period(4'd15, 18);
        if (!done) begin
            done = 1;
            report();
            $finish;
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
            $finish;
        end
    end

endmodule